// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the register front end for a two-channel asynchronous serial controller. It sits on a byte-wide bus with separate read and write strobes. It decodes a small register window for each channel. From the values written there it drives the control signals for the transmit and receive engines: the enables, the one-shot resets, the break request, the frame format, the FIFO mode and the rate codes.

Three mode registers share one address. An internal pointer selects which of them is reached, and it moves forward by itself after each access. The command register carries two things: enable and disable bits for the two directions, and a command code. The code can move the pointer, fire reset pulses, clear the error flags or control break. The shift engines, the rate generator and the FIFO storage are outside this block. They appear only as live status inputs, error event inputs, a receive data byte, and pop and push strobes.

Top module: `urf_dual_uart`

## Requirements
- R1: Channel n occupies addresses n*8 to n*8+7. The offsets are:
  - 0: mode registers.
  - 1: status on read, clock select on write.
  - 2: command, write only; it reads as 0.
  - 3: receive data on read, transmit data on write.
  Offsets 4 to 7 read as 0 and ignore writes. Read data is combinational while the read strobe is high, and 0 otherwise.
- R2: After reset:
  - both enables and the break request are low;
  - all mode registers and the clock select register are 0;
  - all sticky flags are clear;
  - every pointer selects mode register 1.
- R3: The pointer selects mode register 0, 1 or 2. Any read or write at offset 0 reaches the selected register and then moves the pointer: from 0 to 1, from 1 to 2, and it stays at 2 once there. Command code 0x1 sets the pointer to 1, code 0xB sets it to 0, and code 0x2 (receiver reset) also sets it to 1.
- R4: The frame and FIFO outputs come from the mode register fields:
  - mode register 1 bits[1:0]: data-length code (0 to 3 give 5 to 8 data bits);
  - mode register 1 bits[4:2]: parity code (0 even, 1 odd, 4 none);
  - mode register 2 bits[3:0]: stop code (0x7 one stop bit, 0xF two);
  - mode register 0 bit3: deep FIFO mode;
  - mode register 0 bit4: half-full transmit-ready level;
  - mode register 0 bits[2:0]: extended rate table select.
- R5: A write at offset 1 sets the transmit rate code from bits[7:4] and the receive rate code from bits[3:0].
- R6: In a command write, bit0 enables the receiver, bit1 disables it, bit2 enables the transmitter and bit3 disables it. When the enable and disable bits for one direction are both set, the direction ends up disabled. When neither is set, the enable is unchanged. The new state shows after the clock edge that takes the write.
- R7: Command code 0x2 (bits[7:4]) raises the receiver reset output and code 0x3 raises the transmitter reset output. Each is a single-cycle pulse in the cycle after the write. The enable bits written in the same byte also take effect.
- R8: Code 0x6 sets the break request output and code 0x7 clears it.
- R9: Status read bits:
  - bits 0 to 3 are the live inputs: receiver ready, FIFO full, transmitter ready, transmitter empty;
  - bits 4 to 7 are sticky flags for overrun, parity error, framing error and received break;
  - each flag is set by a one-cycle pulse on its event input.
- R10: Code 0x4 clears the overrun, parity and framing flags. Code 0x5 clears the break flag. An event pulse in the same cycle as the clearing command leaves its flag set.
- R11: A read at offset 3 raises the receive pop output of the addressed channel only, in the same cycle, and returns that channel's receive byte. A write at offset 3 raises that channel's transmit push, with the write data on the transmit data output.
- R12: An access to one channel leaves every register and output of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Register address: bit3 selects the channel, bits[2:0] the offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| rx_data_i | input | 16 | Receive byte for each channel, 8 bits per channel |
| rx_rdy_i | input | 2 | Receiver ready, per channel |
| fifo_full_i | input | 2 | Receive FIFO full, per channel |
| tx_rdy_i | input | 2 | Transmitter ready, per channel |
| tx_emt_i | input | 2 | Transmitter empty, per channel |
| ovr_set_i | input | 2 | Overrun event pulse, per channel |
| par_set_i | input | 2 | Parity error event pulse, per channel |
| frm_set_i | input | 2 | Framing error event pulse, per channel |
| brk_set_i | input | 2 | Received break event pulse, per channel |
| rx_pop_o | output | 2 | Receive data taken, per channel |
| tx_push_o | output | 2 | Transmit data offered, per channel |
| tx_data_o | output | 8 | Transmit data byte |
| rx_en_o | output | 2 | Receiver enable, per channel |
| tx_en_o | output | 2 | Transmitter enable, per channel |
| rx_rst_o | output | 2 | Receiver reset pulse, per channel |
| tx_rst_o | output | 2 | Transmitter reset pulse, per channel |
| brk_on_o | output | 2 | Break request, per channel |
| data_bits_o | output | 4 | Data-length code, 2 bits per channel |
| parity_o | output | 6 | Parity code, 3 bits per channel |
| stop_o | output | 8 | Stop code, 4 bits per channel |
| fifo_deep_o | output | 2 | Deep FIFO mode, per channel |
| tx_half_o | output | 2 | Half-full transmit-ready level, per channel |
| baud_ext_o | output | 6 | Extended rate table select, 3 bits per channel |
| tx_rate_o | output | 8 | Transmit rate code, 4 bits per channel |
| rx_rate_o | output | 8 | Receive rate code, 4 bits per channel |

## Verification
The hardest state to reach is a mode register pointer in a known position after a long mixed history. That history includes reads that also advance the pointer, receiver resets that move it back, and pointer commands interleaved with accesses to the other channel. The stimulus starts with directed walks that step the pointer through mode registers 0, 1 and 2 and past 2. It then issues about a thousand random reads, writes and commands across both channels. A bench model tracks every pointer, so each offset-0 read shows whether the design and the model still agree. Error events are also injected in the same cycle as a clearing command, to check that the event wins.

// File: rtl/urf_pkg.sv
package urf_pkg;
   typedef enum logic [1:0] {
      PTR_M0 = 2'd0,
      PTR_M1 = 2'd1,
      PTR_M2 = 2'd2
   } mptr_t;

   localparam int OFSW = 3;
   localparam logic [OFSW-1:0] OFS_MODE = 3'd0;
   localparam logic [OFSW-1:0] OFS_STAT = 3'd1;
   localparam logic [OFSW-1:0] OFS_CMD  = 3'd2;
   localparam logic [OFSW-1:0] OFS_DATA = 3'd3;

   localparam logic [3:0] CMD_PTR1   = 4'h1;
   localparam logic [3:0] CMD_RXRST  = 4'h2;
   localparam logic [3:0] CMD_TXRST  = 4'h3;
   localparam logic [3:0] CMD_ERRCLR = 4'h4;
   localparam logic [3:0] CMD_BRKCLR = 4'h5;
   localparam logic [3:0] CMD_BRKON  = 4'h6;
   localparam logic [3:0] CMD_BRKOFF = 4'h7;
   localparam logic [3:0] CMD_PTR0   = 4'hB;
endpackage

// File: rtl/urf_mode_bank.sv
module urf_mode_bank
   import urf_pkg::*;
#(
   parameter int DW    = 8,
   parameter int NMODE = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          acc_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wd_i,
   input  logic          to_m0_i,
   input  logic          to_m1_i,
   output logic [DW-1:0] rd_o,
   output logic [DW-1:0] m0_o,
   output logic [DW-1:0] m1_o,
   output logic [DW-1:0] m2_o
);
   mptr_t ptr_q;
   logic [DW-1:0] mr_q [NMODE];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ptr_q <= PTR_M1;
      end else if (to_m0_i) begin
         ptr_q <= PTR_M0;
      end else if (to_m1_i) begin
         ptr_q <= PTR_M1;
      end else if (acc_i) begin
         case (ptr_q)
            PTR_M0:  ptr_q <= PTR_M1;
            default: ptr_q <= PTR_M2;
         endcase
      end
   end

   for (genvar k = 0; k < NMODE; k++) begin : g_mr
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            mr_q[k] <= '0;
         end else if (wr_i && (int'(ptr_q) == k)) begin
            mr_q[k] <= wd_i;
         end
      end
   end

   assign rd_o = mr_q[ptr_q];
   assign m0_o = mr_q[0];
   assign m1_o = mr_q[1];
   assign m2_o = mr_q[2];

   // R3: pointer walk
   assert_m0_to_m1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_i && !to_m0_i && !to_m1_i && ptr_q == PTR_M0) |=> ptr_q == PTR_M1);
   assert_m2_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_i && !to_m0_i && !to_m1_i && ptr_q == PTR_M2) |=> ptr_q == PTR_M2);
   assert_m0_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      to_m0_i |=> ptr_q == PTR_M0);
   // R4: mode contents only move on a write
   assert_mode_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(m1_o));
endmodule

// File: rtl/urf_cmd_unit.sv
module urf_cmd_unit
   import urf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cmd_wr_i,
   input  logic [DW-1:0] cmd_i,
   input  logic          ovr_set_i,
   input  logic          par_set_i,
   input  logic          frm_set_i,
   input  logic          brk_set_i,
   output logic          rx_en_o,
   output logic          tx_en_o,
   output logic          rx_rst_o,
   output logic          tx_rst_o,
   output logic          brk_on_o,
   output logic [3:0]    flags_o,
   output logic          to_m0_o,
   output logic          to_m1_o
);
   logic [3:0] code;
   logic       do_rxrst, do_txrst, do_errclr, do_brkclr, do_brkon, do_brkoff;
   logic [3:0] set_v, clr_v;

   assign code      = cmd_i[7:4];
   assign do_rxrst  = cmd_wr_i && (code == CMD_RXRST);
   assign do_txrst  = cmd_wr_i && (code == CMD_TXRST);
   assign do_errclr = cmd_wr_i && (code == CMD_ERRCLR);
   assign do_brkclr = cmd_wr_i && (code == CMD_BRKCLR);
   assign do_brkon  = cmd_wr_i && (code == CMD_BRKON);
   assign do_brkoff = cmd_wr_i && (code == CMD_BRKOFF);
   assign to_m0_o   = cmd_wr_i && (code == CMD_PTR0);
   assign to_m1_o   = cmd_wr_i && ((code == CMD_PTR1) || (code == CMD_RXRST));

   assign set_v = {brk_set_i, frm_set_i, par_set_i, ovr_set_i};
   assign clr_v = {do_brkclr, {3{do_errclr}}};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rx_en_o  <= 1'b0;
         tx_en_o  <= 1'b0;
         rx_rst_o <= 1'b0;
         tx_rst_o <= 1'b0;
         brk_on_o <= 1'b0;
         flags_o  <= '0;
      end else begin
         rx_rst_o <= do_rxrst;
         tx_rst_o <= do_txrst;
         flags_o  <= (flags_o & ~clr_v) | set_v;
         if (do_brkon) begin
            brk_on_o <= 1'b1;
         end else if (do_brkoff) begin
            brk_on_o <= 1'b0;
         end
         if (cmd_wr_i) begin
            if (cmd_i[1]) begin
               rx_en_o <= 1'b0;
            end else if (cmd_i[0]) begin
               rx_en_o <= 1'b1;
            end
            if (cmd_i[3]) begin
               tx_en_o <= 1'b0;
            end else if (cmd_i[2]) begin
               tx_en_o <= 1'b1;
            end
         end
      end
   end

   assert_rx_dis_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && cmd_i[1]) |=> !rx_en_o);
   assert_tx_dis_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && cmd_i[3]) |=> !tx_en_o);
   assert_rxrst_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_rst_o |-> $past(cmd_wr_i));
   assert_brk_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && code == CMD_BRKON) |=> brk_on_o);
   assert_errclr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && code == CMD_ERRCLR && !ovr_set_i) |=> !flags_o[0]);
   assert_event_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      par_set_i |=> flags_o[1]);
endmodule

// File: rtl/urf_channel.sv
module urf_channel
   import urf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            sel_i,
   input  logic [OFSW-1:0] off_i,
   input  logic            wr_i,
   input  logic            rd_i,
   input  logic [DW-1:0]   wd_i,
   input  logic [DW-1:0]   rx_data_i,
   input  logic            rx_rdy_i,
   input  logic            fifo_full_i,
   input  logic            tx_rdy_i,
   input  logic            tx_emt_i,
   input  logic            ovr_set_i,
   input  logic            par_set_i,
   input  logic            frm_set_i,
   input  logic            brk_set_i,
   output logic [DW-1:0]   rd_o,
   output logic            rx_pop_o,
   output logic            tx_push_o,
   output logic            rx_en_o,
   output logic            tx_en_o,
   output logic            rx_rst_o,
   output logic            tx_rst_o,
   output logic            brk_on_o,
   output logic [1:0]      data_bits_o,
   output logic [2:0]      parity_o,
   output logic [3:0]      stop_o,
   output logic            fifo_deep_o,
   output logic            tx_half_o,
   output logic [2:0]      baud_ext_o,
   output logic [3:0]      tx_rate_o,
   output logic [3:0]      rx_rate_o
);
   logic          mode_acc, mode_wr, cs_wr, cmd_wr;
   logic          to_m0, to_m1;
   logic [DW-1:0] mode_rd, m0, m1, m2, cs_q;
   logic [3:0]    flags;

   assign mode_acc  = sel_i && (wr_i || rd_i) && (off_i == OFS_MODE);
   assign mode_wr   = sel_i && wr_i && (off_i == OFS_MODE);
   assign cs_wr     = sel_i && wr_i && (off_i == OFS_STAT);
   assign cmd_wr    = sel_i && wr_i && (off_i == OFS_CMD);
   assign rx_pop_o  = sel_i && rd_i && (off_i == OFS_DATA);
   assign tx_push_o = sel_i && wr_i && (off_i == OFS_DATA);

   urf_mode_bank #(.DW(DW), .NMODE(3)) u_mode (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .acc_i   (mode_acc),
      .wr_i    (mode_wr),
      .wd_i    (wd_i),
      .to_m0_i (to_m0),
      .to_m1_i (to_m1),
      .rd_o    (mode_rd),
      .m0_o    (m0),
      .m1_o    (m1),
      .m2_o    (m2)
   );

   urf_cmd_unit #(.DW(DW)) u_cmd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_wr_i  (cmd_wr),
      .cmd_i     (wd_i),
      .ovr_set_i (ovr_set_i),
      .par_set_i (par_set_i),
      .frm_set_i (frm_set_i),
      .brk_set_i (brk_set_i),
      .rx_en_o   (rx_en_o),
      .tx_en_o   (tx_en_o),
      .rx_rst_o  (rx_rst_o),
      .tx_rst_o  (tx_rst_o),
      .brk_on_o  (brk_on_o),
      .flags_o   (flags),
      .to_m0_o   (to_m0),
      .to_m1_o   (to_m1)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cs_q <= '0;
      end else if (cs_wr) begin
         cs_q <= wd_i;
      end
   end

   always_comb begin
      rd_o = '0;
      if (sel_i && rd_i) begin
         case (off_i)
            OFS_MODE: rd_o = mode_rd;
            OFS_STAT: rd_o = {flags, tx_emt_i, tx_rdy_i, fifo_full_i, rx_rdy_i};
            OFS_DATA: rd_o = rx_data_i;
            default:  rd_o = '0;
         endcase
      end
   end

   assign data_bits_o = m1[1:0];
   assign parity_o    = m1[4:2];
   assign stop_o      = m2[3:0];
   assign fifo_deep_o = m0[3];
   assign tx_half_o   = m0[4];
   assign baud_ext_o  = m0[2:0];
   assign tx_rate_o   = cs_q[7:4];
   assign rx_rate_o   = cs_q[3:0];

   assert_cs_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_wr |=> (tx_rate_o == $past(wd_i[7:4])) && (rx_rate_o == $past(wd_i[3:0])));
   assert_unsel_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i |=> ($stable(cs_q) && !rx_rst_o && !tx_rst_o));
endmodule

// File: rtl/urf_dual_uart.sv
module urf_dual_uart
   import urf_pkg::*;
#(
   parameter int NCH = 2,
   parameter int DW  = 8,
   localparam int CHW = $clog2(NCH),
   localparam int AW  = CHW + OFSW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [AW-1:0]    addr_i,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   input  logic [NCH*DW-1:0] rx_data_i,
   input  logic [NCH-1:0]   rx_rdy_i,
   input  logic [NCH-1:0]   fifo_full_i,
   input  logic [NCH-1:0]   tx_rdy_i,
   input  logic [NCH-1:0]   tx_emt_i,
   input  logic [NCH-1:0]   ovr_set_i,
   input  logic [NCH-1:0]   par_set_i,
   input  logic [NCH-1:0]   frm_set_i,
   input  logic [NCH-1:0]   brk_set_i,
   output logic [NCH-1:0]   rx_pop_o,
   output logic [NCH-1:0]   tx_push_o,
   output logic [DW-1:0]    tx_data_o,
   output logic [NCH-1:0]   rx_en_o,
   output logic [NCH-1:0]   tx_en_o,
   output logic [NCH-1:0]   rx_rst_o,
   output logic [NCH-1:0]   tx_rst_o,
   output logic [NCH-1:0]   brk_on_o,
   output logic [NCH*2-1:0] data_bits_o,
   output logic [NCH*3-1:0] parity_o,
   output logic [NCH*4-1:0] stop_o,
   output logic [NCH-1:0]   fifo_deep_o,
   output logic [NCH-1:0]   tx_half_o,
   output logic [NCH*3-1:0] baud_ext_o,
   output logic [NCH*4-1:0] tx_rate_o,
   output logic [NCH*4-1:0] rx_rate_o
);
   if (NCH < 2 || DW != 8) begin : g_bad_cfg
      $error("urf_dual_uart: NCH must be at least 2 and DW must be 8");
   end

   logic [DW-1:0]   ch_rd [NCH];
   logic [CHW-1:0]  ch_idx;
   logic [OFSW-1:0] off;

   assign ch_idx    = addr_i[AW-1:OFSW];
   assign off       = addr_i[OFSW-1:0];
   assign tx_data_o = wdata_i;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      urf_channel #(.DW(DW)) u_ch (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .sel_i       (int'(ch_idx) == c),
         .off_i       (off),
         .wr_i        (wr_i),
         .rd_i        (rd_i),
         .wd_i        (wdata_i),
         .rx_data_i   (rx_data_i[c*DW +: DW]),
         .rx_rdy_i    (rx_rdy_i[c]),
         .fifo_full_i (fifo_full_i[c]),
         .tx_rdy_i    (tx_rdy_i[c]),
         .tx_emt_i    (tx_emt_i[c]),
         .ovr_set_i   (ovr_set_i[c]),
         .par_set_i   (par_set_i[c]),
         .frm_set_i   (frm_set_i[c]),
         .brk_set_i   (brk_set_i[c]),
         .rd_o        (ch_rd[c]),
         .rx_pop_o    (rx_pop_o[c]),
         .tx_push_o   (tx_push_o[c]),
         .rx_en_o     (rx_en_o[c]),
         .tx_en_o     (tx_en_o[c]),
         .rx_rst_o    (rx_rst_o[c]),
         .tx_rst_o    (tx_rst_o[c]),
         .brk_on_o    (brk_on_o[c]),
         .data_bits_o (data_bits_o[c*2 +: 2]),
         .parity_o    (parity_o[c*3 +: 3]),
         .stop_o      (stop_o[c*4 +: 4]),
         .fifo_deep_o (fifo_deep_o[c]),
         .tx_half_o   (tx_half_o[c]),
         .baud_ext_o  (baud_ext_o[c*3 +: 3]),
         .tx_rate_o   (tx_rate_o[c*4 +: 4]),
         .rx_rate_o   (rx_rate_o[c*4 +: 4])
      );
   end

   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NCH; c++) begin
         rdata_o = rdata_o | ch_rd[c];
      end
   end

   assert_one_pop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rx_pop_o) && $onehot0(tx_push_o));
   assert_idle_rdata_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |-> rdata_o == '0);
endmodule

// File: tb/urf_dual_uart_test.sv
module urf_dual_uart_test;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [3:0]  addr_i = '0;
   logic        wr_i = 1'b0;
   logic        rd_i = 1'b0;
   logic [7:0]  wdata_i = '0;
   logic [7:0]  rdata_o;
   logic [15:0] rx_data_i = '0;
   logic [1:0]  rx_rdy_i = '0, fifo_full_i = '0, tx_rdy_i = '0, tx_emt_i = '0;
   logic [1:0]  ovr_set_i = '0, par_set_i = '0, frm_set_i = '0, brk_set_i = '0;
   logic [1:0]  rx_pop_o, tx_push_o, rx_en_o, tx_en_o, rx_rst_o, tx_rst_o, brk_on_o;
   logic [7:0]  tx_data_o;
   logic [3:0]  data_bits_o;
   logic [5:0]  parity_o, baud_ext_o;
   logic [7:0]  stop_o, tx_rate_o, rx_rate_o;
   logic [1:0]  fifo_deep_o, tx_half_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] m_mr [2][3];
   int         m_ptr [2];
   bit         m_rxen [2], m_txen [2], m_brk [2];
   bit  [3:0]  m_flag [2];
   logic [7:0] m_cs [2];
   bit  [1:0]  m_rxp, m_txp;

   urf_dual_uart uut (.*);

   always #2 clk_i = ~clk_i;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int next_ptr(input int p);
      return (p >= 1) ? 2 : 1;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < 3; k++) m_mr[c][k] = '0;
         m_ptr[c] = 1; m_rxen[c] = 0; m_txen[c] = 0; m_brk[c] = 0;
         m_flag[c] = '0; m_cs[c] = '0;
      end
      m_rxp = '0; m_txp = '0;
   endtask

   task automatic check_all();
      for (int c = 0; c < 2; c++) begin
         chk("R6 rx_en", rx_en_o[c], m_rxen[c]);
         chk("R6 tx_en", tx_en_o[c], m_txen[c]);
         chk("R7 rx_rst", rx_rst_o[c], m_rxp[c]);
         chk("R7 tx_rst", tx_rst_o[c], m_txp[c]);
         chk("R8 brk", brk_on_o[c], m_brk[c]);
         chk("R4 data_bits", data_bits_o[c*2 +: 2], m_mr[c][1][1:0]);
         chk("R4 parity", parity_o[c*3 +: 3], m_mr[c][1][4:2]);
         chk("R4 stop", stop_o[c*4 +: 4], m_mr[c][2][3:0]);
         chk("R4 deep", fifo_deep_o[c], m_mr[c][0][3]);
         chk("R4 half", tx_half_o[c], m_mr[c][0][4]);
         chk("R4 baud_ext", baud_ext_o[c*3 +: 3], m_mr[c][0][2:0]);
         chk("R5 tx_rate", tx_rate_o[c*4 +: 4], m_cs[c][7:4]);
         chk("R5 rx_rate", rx_rate_o[c*4 +: 4], m_cs[c][3:0]);
      end
   endtask

   task automatic cycle_op(input bit wr, input bit rd, input logic [3:0] a, input logic [7:0] d,
                           input logic [1:0] ov, input logic [1:0] pa,
                           input logic [1:0] fr, input logic [1:0] bk);
      int ch;
      int off;
      logic [7:0] exp_rd;
      logic [3:0] code;
      @(negedge clk_i);
      wr_i = wr; rd_i = rd; addr_i = a; wdata_i = d;
      ovr_set_i = ov; par_set_i = pa; frm_set_i = fr; brk_set_i = bk;
      rx_rdy_i = 2'($urandom); fifo_full_i = 2'($urandom);
      tx_rdy_i = 2'($urandom); tx_emt_i = 2'($urandom);
      rx_data_i = 16'($urandom);
      #1;
      ch = int'(a[3]); off = int'(a[2:0]);
      code = d[7:4];
      exp_rd = '0;
      if (rd) begin
         case (off)
            0: exp_rd = m_mr[ch][m_ptr[ch]];
            1: exp_rd = {m_flag[ch], tx_emt_i[ch], tx_rdy_i[ch], fifo_full_i[ch], rx_rdy_i[ch]};
            3: exp_rd = rx_data_i[ch*8 +: 8];
            default: exp_rd = '0;
         endcase
         case (off)
            0: chk("R3 mode readback", rdata_o, exp_rd);
            1: chk("R9 status", rdata_o, exp_rd);
            3: chk("R11 rx data", rdata_o, exp_rd);
            default: chk("R1 empty offset", rdata_o, exp_rd);
         endcase
      end
      chk("R11 rx_pop", rx_pop_o, (rd && off == 3) ? (2'b01 << ch) : 2'b00);
      chk("R11 tx_push", tx_push_o, (wr && off == 3) ? (2'b01 << ch) : 2'b00);
      if (wr && off == 3) chk("R11 tx_data", tx_data_o, d);
      // model update for the edge
      m_rxp = '0; m_txp = '0;
      for (int c = 0; c < 2; c++) begin
         bit [3:0] clr;
         clr = '0;
         if (wr && off == 2 && c == ch && code == 4'h4) clr = 4'b0111;
         if (wr && off == 2 && c == ch && code == 4'h5) clr = 4'b1000;
         m_flag[c] = (m_flag[c] & ~clr) | {bk[c], fr[c], pa[c], ov[c]};
      end
      if (off == 0 && (wr || rd)) begin
         if (wr) m_mr[ch][m_ptr[ch]] = d;
         m_ptr[ch] = next_ptr(m_ptr[ch]);
      end
      if (wr && off == 1) m_cs[ch] = d;
      if (wr && off == 2) begin
         if (d[1]) m_rxen[ch] = 0; else if (d[0]) m_rxen[ch] = 1;
         if (d[3]) m_txen[ch] = 0; else if (d[2]) m_txen[ch] = 1;
         case (code)
            4'h1: m_ptr[ch] = 1;
            4'hB: m_ptr[ch] = 0;
            4'h2: begin m_ptr[ch] = 1; m_rxp[ch] = 1'b1; end
            4'h3: m_txp[ch] = 1'b1;
            4'h6: m_brk[ch] = 1;
            4'h7: m_brk[ch] = 0;
            default: ;
         endcase
      end
      @(posedge clk_i);
      @(negedge clk_i);
      wr_i = 0; rd_i = 0;
      ovr_set_i = '0; par_set_i = '0; frm_set_i = '0; brk_set_i = '0;
      check_all();
      m_rxp = '0; m_txp = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cycle_op(1, 0, a, d, 2'b00, 2'b00, 2'b00, 2'b00);
   endtask

   task automatic rd(input logic [3:0] a);
      cycle_op(0, 1, a, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      model_reset();
      repeat (4) @(negedge clk_i);
      rst_ni = 1'b1;
      // R2: reset state
      check_all();
      chk("R1 idle rdata", rdata_o, 8'h00);
      rd(4'h0);                    // R2: pointer starts at mode register 1
      rd(4'h8);

      // R3, R4: walk the pointer from mode register 0
      wr(4'h2, 8'hB0);
      wr(4'h0, 8'h1D);
      wr(4'h0, 8'h13);
      wr(4'h0, 8'h0F);
      wr(4'h0, 8'h07);             // R3: stays on mode register 2
      wr(4'h2, 8'h10);
      rd(4'h0); rd(4'h0); rd(4'h0);
      wr(4'h2, 8'hB0);
      rd(4'h0); rd(4'h0);
      wr(4'h2, 8'hB0);
      wr(4'h2, 8'h20);             // R3: receiver reset returns pointer to 1
      rd(4'h0);

      // R6, R7: enable and disable resolution, combined byte
      wr(4'h2, 8'h05);
      wr(4'h2, 8'h03);
      wr(4'h2, 8'h0F);
      wr(4'h2, 8'h25);
      wr(4'h2, 8'h30);
      wr(4'h2, 8'h0C);

      // R8: break control
      wr(4'hA, 8'h60);
      wr(4'hA, 8'h70);

      // R9, R10: sticky flags, clear versus same-cycle event
      cycle_op(1, 0, 4'h4, 8'hFF, 2'b01, 2'b01, 2'b01, 2'b11); // R1: offset 4 write ignored
      rd(4'h1); rd(4'h9);
      cycle_op(1, 0, 4'h2, 8'h40, 2'b00, 2'b01, 2'b00, 2'b00);
      rd(4'h1);
      wr(4'h2, 8'h50);
      rd(4'h1); rd(4'h9);

      // R5, R12: clock select on one channel leaves the other alone
      wr(4'h9, 8'hA5);
      wr(4'h1, 8'h3C);
      rd(4'h3); rd(4'hB);          // R11
      wr(4'hB, 8'h5A);

      // random mix over both channels (R1, R3, R9, R10, R11, R12)
      for (int i = 0; i < 1200; i++) begin
         int kind;
         logic [3:0] a;
         logic [7:0] d;
         logic [3:0] codes [9];
         codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB};
         kind = int'($urandom % 4);
         a = 4'($urandom);
         d = 8'($urandom);
         if (kind == 3) begin
            a[2:0] = 3'd2;
            d[7:4] = codes[$urandom % 9];
         end else if (kind == 2) begin
            a[2:0] = 3'($urandom % 2);
         end
         cycle_op(kind != 1, kind == 1, a, d,
                  2'(($urandom % 8 == 0) ? $urandom : 0),
                  2'(($urandom % 8 == 0) ? $urandom : 0),
                  2'(($urandom % 8 == 0) ? $urandom : 0),
                  2'(($urandom % 8 == 0) ? $urandom : 0));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule